// File: doc/BRIEF.md
# SPI Master Transfer-Mode Sequencer

This block is the shift control on the master side of a Motorola-style SPI link. It takes frames from a transmit FIFO read port and shifts them out on `txd`, most significant bit first. At the same time it samples `rxd` and writes the completed frames, right-justified, to a receive FIFO write port. The serial clock rests low. `txd` changes after each falling edge of `sclk`, and `rxd` is sampled on each rising edge. `cs_n` stays low for the whole transfer, and `busy` reports that a transfer is in progress.

A 2-bit mode, captured when a transfer starts, selects one of four modes:

- **Full duplex:** transmits and stores every frame.
- **Transmit only:** transmits frames and discards what arrives on `rxd`.
- **Receive only:** pops one dummy entry and holds `txd` low.
- **EEPROM read:** sends the FIFO contents as opcode and address, ignoring `rxd`, then receives with `txd` low.

The two transmit modes stop when the transmit FIFO is empty at a frame boundary. The two receive modes stop after a programmed count N, plus one, of stored frames. The frame width can be set from 1 to `DATA_W` bits.

Top module: `spi_xfer_seq`

## Requirements
- R1: A transfer starts only in a cycle where `enable` and `slave_sel` are both high and `tx_empty` is low. Otherwise `cs_n` stays high, `busy` stays low and no entry is popped.
- R2: `busy` is high whenever `cs_n` is low. `cs_n` rises, and `busy` falls, exactly 2*HALF_DIV clock cycles (one serial clock period) after the last falling edge of `sclk` in the transfer.
- R3: Each transmitted frame sends the low `frame_len_m1+1` bits of its FIFO entry, MSB first, one bit per `sclk` period. Bits above the frame width are ignored. `sclk` is low while `cs_n` is high.
- R4: Mode 2'b00 (full duplex) pushes one receive entry per frame. Each entry holds the rxd bits of that frame, the first bit in position `frame_len_m1`, with zeros above the frame width.
- R5: Mode 2'b01 (transmit only) never asserts `rx_push`.
- R6: Mode 2'b10 (receive only) pops exactly one transmit entry, holds `txd` at 0 during the transfer, and runs and stores exactly N+1 frames, where N is `frame_cnt`.
- R7: In mode 2'b11 (EEPROM read), the first phase transmits every entry the FIFO holds and pushes nothing while it runs.
- R8: In mode 2'b11, once the FIFO is empty at a frame boundary, the block runs N+1 more frames with `txd` at 0 and stores exactly those frames.
- R9: In modes 2'b00 and 2'b01, the number of frames equals the number of FIFO entries present (no refill during the transfer). The transfer ends at the first frame boundary where the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enabled |
| slave_sel | input | 1 | A slave is selected for the next transfer |
| mode | input | 2 | Transfer mode: 00 duplex, 01 tx only, 10 rx only, 11 EEPROM read |
| frame_len_m1 | input | LEN_W | Frame width minus one |
| frame_cnt | input | CNT_W | Receive frame count N (N+1 frames stored) |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DATA_W | Head entry of the transmit FIFO |
| tx_pop | output | 1 | Pop pulse to the transmit FIFO |
| rx_push | output | 1 | Push pulse to the receive FIFO |
| rx_data | output | DATA_W | Right-justified received frame |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |

## Verification
A wrong frame-boundary decision shows up within one frame. The frame count on `sclk` comes out wrong, `tx_pop` pulses too many or too few times, or `cs_n` releases early or late. A bit counter that is off by one shifts every later captured bit and every `rx_data` value from the first frame onward. A mode or phase flag in the wrong state either lets `rx_push` fire where none is allowed, or leaves `txd` non-zero in a receive phase, and both are visible on the next frame. The sweep covers every mode, several frame widths, FIFO fill levels and counts, and compares every serial bit and every stored word against values computed arithmetically.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    XM_DUPLEX = 2'b00,
    XM_TXONLY = 2'b01,
    XM_RXONLY = 2'b10,
    XM_EEPROM = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_TAIL  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/spi_seq_sclk.sv
// Serial clock generator: half period of HALF_DIV system clocks, idle low.
module spi_seq_sclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = run && (cnt == CW'(HALF_DIV - 1));
  assign rise_tick = tick && !sclk;
  assign fall_tick = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/spi_seq_shift.sv
// Transmit and receive shift registers with programmable frame width.
module spi_seq_shift #(
  parameter int DW = 32,
  parameter int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic [LW-1:0] len_m1,
  input  logic          shift_out,
  input  logic          sample,
  input  logic          rxd,
  output logic          out_bit,
  output logic [DW-1:0] rx_word
);
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] ones;
  logic [DW-1:0] mask;

  assign ones    = '1;
  assign mask    = ~((ones << len_m1) << 1);
  assign out_bit = tx_sh[DW-1];
  assign rx_word = rx_sh & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
    end else if (load) begin
      // align the frame MSB to the top of the register
      tx_sh <= load_data << (LW'(DW - 1) - len_m1);
    end else if (shift_out) begin
      tx_sh <= tx_sh << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh <= '0;
    end else if (sample) begin
      rx_sh <= {rx_sh[DW-2:0], rxd};
    end
  end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 16,
  localparam int LEN_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              slave_sel,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  frame_len_m1,
  input  logic [CNT_W-1:0]  frame_cnt,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              cs_n,
  output logic              txd,
  input  logic              rxd,
  output logic              busy
);
  localparam int TAIL_W = $clog2(2 * HALF_DIV + 1);

  seq_state_e        state;
  xfer_mode_e        mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  rx_cnt;
  logic [TAIL_W-1:0] tail_cnt;
  logic              tx_phase;
  logic              rise_tick, fall_tick;
  logic              out_bit;
  logic [DATA_W-1:0] rx_word;

  logic start, frame_end, store_now, last_rx, more, reload, load, shift_out;

  assign start     = (state == ST_IDLE) && enable && slave_sel && !tx_empty;
  assign frame_end = (state == ST_SHIFT) && fall_tick && (bit_cnt == len_q);
  assign store_now = frame_end && ((mode_q == XM_DUPLEX) || (mode_q == XM_RXONLY) ||
                                   ((mode_q == XM_EEPROM) && !tx_phase));
  assign last_rx   = (rx_cnt == cnt_q);
  assign load      = start || (frame_end && reload);
  assign shift_out = (state == ST_SHIFT) && fall_tick && !frame_end;

  // continuation decision at a frame boundary
  always_comb begin
    more   = 1'b0;
    reload = 1'b0;
    unique case (mode_q)
      XM_DUPLEX, XM_TXONLY: begin
        more   = !tx_empty;
        reload = !tx_empty;
      end
      XM_RXONLY: more = !last_rx;
      XM_EEPROM: begin
        if (tx_phase) begin
          more   = 1'b1;
          reload = !tx_empty;
        end else begin
          more   = !last_rx;
        end
      end
      default: more = 1'b0;
    endcase
  end

  spi_seq_sclk #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_SHIFT),
    .sclk     (sclk),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  spi_seq_shift #(.DW(DATA_W), .LW(LEN_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_data(tx_data),
    .len_m1   (start ? frame_len_m1 : len_q),
    .shift_out(shift_out),
    .sample   (rise_tick),
    .rxd      (rxd),
    .out_bit  (out_bit),
    .rx_word  (rx_word)
  );

  // txd is low outside the transmit phase and while deselected
  assign txd = tx_phase && out_bit && !cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= XM_DUPLEX;
      len_q    <= '0;
      cnt_q    <= '0;
      rx_cnt   <= '0;
      bit_cnt  <= '0;
      tail_cnt <= '0;
      tx_phase <= 1'b0;
      tx_pop   <= 1'b0;
      rx_push  <= 1'b0;
      rx_data  <= '0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
    end else begin
      tx_pop  <= load;
      rx_push <= store_now;
      if (store_now) rx_data <= rx_word;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_SHIFT;
            mode_q   <= xfer_mode_e'(mode);
            len_q    <= frame_len_m1;
            cnt_q    <= frame_cnt;
            rx_cnt   <= '0;
            bit_cnt  <= '0;
            tx_phase <= (mode != XM_RXONLY);
            cs_n     <= 1'b0;
            busy     <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (frame_end) begin
            bit_cnt <= '0;
            if (store_now) rx_cnt <= rx_cnt + CNT_W'(1);
            if ((mode_q == XM_EEPROM) && tx_phase && tx_empty) tx_phase <= 1'b0;
            if (!more) begin
              state    <= ST_TAIL;
              tail_cnt <= '0;
            end
          end else if (fall_tick) begin
            bit_cnt <= bit_cnt + LEN_W'(1);
          end
        end
        ST_TAIL: begin
          if (tail_cnt == TAIL_W'(2 * HALF_DIV - 1)) begin
            state <= ST_IDLE;
            cs_n  <= 1'b1;
            busy  <= 1'b0;
          end else begin
            tail_cnt <= tail_cnt + TAIL_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_seq_chk.sv
module spi_xfer_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       busy,
  input logic       sclk,
  input logic       txd,
  input logic       tx_pop,
  input logic       rx_push,
  input logic [1:0] mode_q,
  input logic       tx_phase
);
  p_pop_when_busy_r1: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> busy);

  p_busy_cover_cs_r2: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  p_push_single_r4: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);

  p_txonly_no_push_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b01) |-> !rx_push);

  p_rxonly_txd_low_r6: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 2'b10) && !cs_n) |-> !txd);

  p_eeprom_tx_no_push_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 2'b11) && tx_phase) |-> !rx_push);

  p_pop_single_r9: assert property (@(posedge clk) disable iff (rst)
    tx_pop |=> !tx_pop);
endmodule

bind spi_xfer_seq spi_xfer_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .busy    (busy),
  .sclk    (sclk),
  .txd     (txd),
  .tx_pop  (tx_pop),
  .rx_push (rx_push),
  .mode_q  (mode_q),
  .tx_phase(tx_phase)
);

// File: tb/spi_xfer_seq_tb.sv
`timescale 1ns/1ps
module spi_xfer_seq_tb;
  localparam int DW   = 32;
  localparam int HALF = 2;
  localparam int CW   = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          slave_sel = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [4:0]    frame_len_m1 = 5'd7;
  logic [CW-1:0] frame_cnt = '0;
  logic          tx_empty;
  logic [DW-1:0] tx_data;
  logic          tx_pop, rx_push, sclk, cs_n, txd, busy;
  logic [DW-1:0] rx_data;
  logic          rxd = 1'b0;

  always #2 clk = ~clk;

  spi_xfer_seq #(.DATA_W(DW), .HALF_DIV(HALF), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .slave_sel(slave_sel), .mode(mode),
    .frame_len_m1(frame_len_m1), .frame_cnt(frame_cnt), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .cs_n(cs_n), .txd(txd), .rxd(rxd), .busy(busy)
  );

  // transmit FIFO model
  logic [DW-1:0] fifo_mem [0:7];
  int            fifo_wr = 0;
  int            fifo_rd = 0;
  int            pop_cnt = 0;
  logic          fifo_clr = 1'b0;
  assign tx_empty = (fifo_rd == fifo_wr);
  assign tx_data  = fifo_mem[fifo_rd[2:0]];

  always @(posedge clk) begin
    if (fifo_clr) begin
      fifo_rd <= 0;
      pop_cnt <= 0;
    end else if (tx_pop) begin
      fifo_rd <= fifo_rd + 1;
      pop_cnt <= pop_cnt + 1;
    end
  end

  // receive FIFO model
  logic [DW-1:0] rx_got [0:7];
  int            rx_n = 0;
  always @(posedge clk) begin
    if (fifo_clr) rx_n <= 0;
    else if (rx_push) begin
      if (rx_n < 8) rx_got[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  function automatic logic bitfn(input int i);
    return ((i * 5 + i / 3) % 7) > 2;
  endfunction

  // serial slave model, evaluated away from the active edge
  logic cap [0:255];
  int   edge_idx = 0;
  int   since_fall = 0;
  int   tail_len = 0;
  int   done_cnt = 0;
  bit   busy_bad = 1'b0;
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      edge_idx = 0;
      busy_bad = 1'b0;
      rxd = bitfn(0);
    end
    if (!cs_n && !busy) busy_bad = 1'b1;
    if (!prev_sclk && sclk) begin
      if (edge_idx < 256) cap[edge_idx] = txd;
      edge_idx++;
    end
    if (prev_sclk && !sclk) begin
      since_fall = 0;
      rxd = bitfn(edge_idx);
    end else begin
      since_fall++;
    end
    if (!prev_cs && cs_n) begin
      tail_len = since_fall;
      done_cnt++;
    end
    prev_cs   = cs_n;
    prev_sclk = sclk;
  end

  int vectors = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_fifos();
    @(negedge clk);
    fifo_clr = 1'b1;
    fifo_wr  = 0;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  task automatic hold_check(input string what);
    bit bad = 1'b0;
    repeat (16) begin
      @(negedge clk);
      if (!cs_n || busy || pop_cnt != 0) bad = 1'b1;
    end
    chk(!bad, "R1", what, {31'd0, bad}, 32'd0);
  endtask

  task automatic run_xfer(input int m, input int w, input int t, input int n);
    int  d0, nfr, fs, exp_rx, exp_pop, waited, bad_bits;
    string rq_tx, rq_rx;
    clear_fifos();
    for (int k = 0; k < t; k++)
      fifo_mem[k] = (32'h9E3779B9 * (k + 1)) ^ (32'(m) << 8) ^ 32'(w);
    fifo_wr      = t;
    mode         = 2'(m);
    frame_len_m1 = 5'(w - 1);
    frame_cnt    = CW'(n);
    slave_sel    = 1'b1;
    enable       = 1'b1;
    d0           = done_cnt;
    @(negedge clk);
    enable = 1'b0;
    waited = 0;
    while (done_cnt == d0 && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_cnt != d0, "R2", "transfer completion", 32'(done_cnt - d0), 32'd1);
    repeat (2) @(negedge clk);

    nfr     = (m < 2) ? t : (m == 2) ? n + 1 : t + n + 1;
    exp_pop = (m == 2) ? 1 : t;
    exp_rx  = (m == 0) ? t : (m == 1) ? 0 : n + 1;
    fs      = (m == 3) ? t : 0;
    rq_tx   = (m == 2) ? "R6" : (m == 3) ? "R7" : "R3";
    rq_rx   = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R8";

    // frame count on the serial clock (R9 for tx modes, R6/R8 otherwise)
    chk(edge_idx == nfr * w, (m < 2) ? "R9" : rq_rx, "sclk rising edges",
        32'(edge_idx), 32'(nfr * w));

    bad_bits = 0;
    for (int f = 0; f < nfr; f++) begin
      for (int b = 0; b < w; b++) begin
        logic eb;
        eb = ((m < 2) || (m == 3 && f < t)) ? fifo_mem[f][w - 1 - b] : 1'b0;
        if ((f * w + b) < 256 && cap[f * w + b] !== eb) bad_bits++;
      end
    end
    chk(bad_bits == 0, rq_tx, "txd bit errors", 32'(bad_bits), 32'd0);
    chk(pop_cnt == exp_pop, (m == 2) ? "R6" : (m == 3) ? "R7" : "R9",
        "pop count", 32'(pop_cnt), 32'(exp_pop));
    chk(rx_n == exp_rx, rq_rx, "push count", 32'(rx_n), 32'(exp_rx));
    for (int i = 0; i < exp_rx && i < 8 && i < rx_n; i++) begin
      logic [31:0] ev;
      ev = '0;
      for (int b = 0; b < w; b++) ev[w - 1 - b] = bitfn((fs + i) * w + b);
      chk(rx_got[i] === ev, rq_rx, "received word", rx_got[i], ev);
    end
    chk(tail_len == 2 * HALF, "R2", "cs release delay", 32'(tail_len), 32'(2 * HALF));
    chk(!busy_bad && !busy && cs_n, "R2", "busy covers cs", {31'd0, busy_bad}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int widths [5] = '{1, 3, 8, 17, 32};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R2", "reset cs_n/busy", {30'd0, cs_n, busy}, 32'h2);
    chk(sclk === 1'b0 && tx_pop === 1'b0 && rx_push === 1'b0, "R3", "reset sclk/strobes",
        {29'd0, sclk, tx_pop, rx_push}, 32'd0);

    // R1: start gating
    clear_fifos();
    fifo_mem[0] = 32'h1234_5678;
    fifo_wr     = 1;
    enable = 1'b1; slave_sel = 1'b0;
    hold_check("no slave selected");
    enable = 1'b0; slave_sel = 1'b1;
    hold_check("controller disabled");
    fifo_wr = 0;
    enable = 1'b1; slave_sel = 1'b1;
    hold_check("transmit FIFO empty");
    enable = 1'b0;

    for (int m = 0; m < 4; m++)
      for (int wi = 0; wi < 5; wi++)
        for (int t = 1; t <= 3; t++)
          for (int n = 0; n <= 2; n++)
            run_xfer(m, widths[wi], t, n);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule